// File: doc/BRIEF.md
# Three-Dimensional Descriptor DMA Address Sequencer

This block walks one DMA channel through a transfer laid out in three dimensions: arrays of A bytes, B arrays to a frame, and C frames. The transfer is described by an eight-word descriptor held in a small register-array parameter store. Software fills the store one word at a time through a plain write/read port. Each trigger makes the sequencer emit one or more array requests on its output. A request carries a source address, a destination address, a byte count and a flag for the final array. A separate data mover consumes these requests.

Between triggers, a working copy of the active descriptor stays inside the block. The updated position is written back into the active slot so that software can read it. When the last array has been issued, the active slot is refilled from the slot its link field names, or cleared when the link is null. Completion pulses then follow, split into final and intermediate kinds, each carrying the descriptor's completion code. The FSM states are IDLE, XFER, STORE, LINK and NOTIFY. Its transitions are:

- IDLE to XFER (accept): a pending trigger is accepted on a live descriptor.
- IDLE to IDLE (drop): a pending trigger is accepted on a null descriptor and discarded.
- XFER to XFER (next array): frame-synchronised mode, frame not yet finished.
- XFER to STORE (write back): the trigger's work is done, no final array, descriptor not static.
- XFER to LINK (reload): final array issued, descriptor not static.
- XFER to NOTIFY (static end): the trigger's work is done on a static descriptor.
- STORE to NOTIFY and LINK to NOTIFY.
- NOTIFY to IDLE.

Top module: `dma3d_seq`

## Requirements
- R1: After reset every output is 0, the missed-trigger count is 0 and every descriptor word reads 0.
- R2: A write on the register port with `cfg_we` stores `cfg_wdata` at word `cfg_addr[2:0]` of slot `cfg_addr[6:3]`. `cfg_rdata` shows the addressed word combinationally. The descriptor word order is:
  - 0: options
  - 1: source
  - 2: A count in bits 15:0, B count in bits 31:16
  - 3: destination
  - 4: source B index in bits 15:0, destination B index in bits 31:16
  - 5: link in bits 15:0, B reload in bits 31:16
  - 6: source C index in bits 15:0, destination C index in bits 31:16
  - 7: C count in bits 15:0
- R3: With option bit 2 clear, each trigger issues exactly one array of A bytes. Within a frame each array adds the signed B index to the previous address. On the last array of a frame, the signed C index is added to the frame's start address to give the next frame start, and B is reloaded from the B reload value. The first array appears two clock edges after the edge that samples the trigger.
- R4: With option bit 2 set, one trigger issues all remaining arrays of the current frame on consecutive cycles.
- R5: Option bit 0 (source) or bit 1 (destination) set makes that address fixed. The address is then emitted with its low `k` bits cleared, where `k` is the width code in option bits 10:8, and codes 6 and 7 act as 5.
- R6: `xfer_last` is 1 only on the final array of the final frame.
- R7: After the final array of a non-static descriptor whose link is not 0xFFFF, all eight words of slot `link[3:0]` are copied into the active slot 0.
- R8: A link of 0xFFFF clears words 2 and 7 of the active slot instead of copying. A trigger while the active A, B or C count is zero produces no array and no completion pulse.
- R9: Option bit 3 set leaves the active slot unchanged and unlinked. A later trigger repeats the same transfer.
- R10: One cycle after the STORE or LINK state, or right after the last XFER of a static descriptor, NOTIFY raises the completion pulses for one cycle, with `cc_code` equal to option bits 17:12:
  - final completion: `irq_final` if option bit 20 is set, `chain_final` if bit 22 is set
  - intermediate completion: `irq_inter` if bit 21 is set, `chain_inter` if bit 23 is set
- R11: A trigger arriving while the channel is busy is held as one pending event and served later. Each trigger that arrives while one is already pending increments `missed_cnt`, which saturates at its maximum.
- R12: After each non-final trigger on a non-static descriptor, the active slot holds the next source and destination addresses in words 1 and 3, the remaining B count in word 2 bits 31:16 and the remaining C count in word 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 7 | Word address: slot in bits 6:3, word in bits 2:0 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |
| trig | input | 1 | Transfer trigger, one per cycle high |
| xfer_valid | output | 1 | One array request this cycle |
| xfer_src | output | 32 | Source address of the array |
| xfer_dst | output | 32 | Destination address of the array |
| xfer_bytes | output | 16 | Array length in bytes (A count) |
| xfer_last | output | 1 | Final array of the descriptor |
| irq_final | output | 1 | Final completion interrupt pulse |
| irq_inter | output | 1 | Intermediate completion interrupt pulse |
| chain_final | output | 1 | Final completion chain pulse |
| chain_inter | output | 1 | Intermediate completion chain pulse |
| cc_code | output | 6 | Completion code during a pulse |
| missed_cnt | output | 8 | Saturating count of missed triggers |

## Verification
The trigger is sampled at one edge and accepted at the next, so the first array request is visible after the second edge. In frame-synchronised mode the remaining arrays follow on consecutive cycles. The completion pulse comes two cycles after the last array, whether it passes through STORE or LINK, or, for a static descriptor, one cycle after it. The bench drives inputs and samples outputs only on falling edges, and a falling-edge monitor logs every request and completion pulse. Each scenario task waits a fixed number of cycles longer than these latencies before comparing the log and the read-back descriptor words. The two-edge latency of the first array is also checked directly.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 8;
    localparam int CODE_W     = 6;
    localparam int CODE_LSB   = 12;
    localparam logic [15:0] NULL_LINK = 16'hFFFF;

    typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words_t;

    typedef struct packed {
        logic              sam;
        logic              dam;
        logic              absync;
        logic              stat;
        logic [2:0]        fwid;
        logic [CODE_W-1:0] code;
        logic              ie_fin;
        logic              ie_int;
        logic              ce_fin;
        logic              ce_int;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [15:0]       acnt;
        logic [15:0]       bcnt;
        logic [15:0]       sbidx;
        logic [15:0]       dbidx;
        logic [15:0]       link;
        logic [15:0]       brld;
        logic [15:0]       scidx;
        logic [15:0]       dcidx;
        logic [15:0]       ccnt;
    } desc_f_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_XFER   = 3'd1,
        S_STORE  = 3'd2,
        S_LINK   = 3'd3,
        S_NOTIFY = 3'd4
    } seq_state_t;

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] fifo_align(input logic [31:0] a, input logic [2:0] code);
        logic [2:0] c;
        c = (code > 3'd5) ? 3'd5 : code;
        return a & ~((32'd1 << c) - 32'd1);
    endfunction
endpackage

// File: rtl/dma3d_pram.sv
module dma3d_pram
    import dma3d_pkg::*;
#(
    parameter int SLOTS    = 16,
    parameter int ACT_SLOT = 0,
    localparam int SLOT_AW = $clog2(SLOTS),
    localparam int ADDR_W  = SLOT_AW + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    output logic [WORD_W-1:0]     cfg_rdata,
    input  logic [DESC_WORDS-1:0] eng_we,
    input  desc_words_t           eng_wd,
    input  logic [SLOT_AW-1:0]    lnk_sel,
    output desc_words_t           lnk_desc,
    output desc_f_t               act_f
);
    localparam int NWORDS = SLOTS * DESC_WORDS;
    localparam int ABASE  = ACT_SLOT * DESC_WORDS;

    logic [WORD_W-1:0] mem [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else begin
            if (cfg_we) mem[cfg_addr] <= cfg_wdata;
            for (int w = 0; w < DESC_WORDS; w++) begin
                if (eng_we[w]) mem[ABASE + w] <= eng_wd[w];
            end
        end
    end

    assign cfg_rdata = mem[cfg_addr];

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_lnk
        assign lnk_desc[g] = mem[{lnk_sel, 3'(g)}];
    end

    always_comb begin
        act_f.sam    = mem[ABASE][0];
        act_f.dam    = mem[ABASE][1];
        act_f.absync = mem[ABASE][2];
        act_f.stat   = mem[ABASE][3];
        act_f.fwid   = mem[ABASE][10:8];
        act_f.code   = mem[ABASE][CODE_LSB +: CODE_W];
        act_f.ie_fin = mem[ABASE][20];
        act_f.ie_int = mem[ABASE][21];
        act_f.ce_fin = mem[ABASE][22];
        act_f.ce_int = mem[ABASE][23];
        act_f.src    = mem[ABASE + 1];
        act_f.acnt   = mem[ABASE + 2][15:0];
        act_f.bcnt   = mem[ABASE + 2][31:16];
        act_f.dst    = mem[ABASE + 3];
        act_f.sbidx  = mem[ABASE + 4][15:0];
        act_f.dbidx  = mem[ABASE + 4][31:16];
        act_f.link   = mem[ABASE + 5][15:0];
        act_f.brld   = mem[ABASE + 5][31:16];
        act_f.scidx  = mem[ABASE + 6][15:0];
        act_f.dcidx  = mem[ABASE + 6][31:16];
        act_f.ccnt   = mem[ABASE + 7][15:0];
    end
endmodule

// File: rtl/dma3d_step.sv
module dma3d_step
    import dma3d_pkg::*;
(
    input  logic [31:0] src,
    input  logic [31:0] dst,
    input  logic [31:0] fsrc,
    input  logic [31:0] fdst,
    input  logic [15:0] bcnt,
    input  logic [15:0] ccnt,
    input  logic [15:0] brld,
    input  logic [15:0] sbidx,
    input  logic [15:0] dbidx,
    input  logic [15:0] scidx,
    input  logic [15:0] dcidx,
    input  logic        sam,
    input  logic        dam,
    output logic [31:0] n_src,
    output logic [31:0] n_dst,
    output logic [31:0] n_fsrc,
    output logic [31:0] n_fdst,
    output logic [15:0] n_bcnt,
    output logic [15:0] n_ccnt,
    output logic        frame_end,
    output logic        is_final
);
    always_comb begin
        frame_end = (bcnt <= 16'd1);
        is_final  = frame_end && (ccnt <= 16'd1);
        if (!frame_end) begin
            n_src  = sam ? src : src + sx16(sbidx);
            n_dst  = dam ? dst : dst + sx16(dbidx);
            n_fsrc = fsrc;
            n_fdst = fdst;
            n_bcnt = bcnt - 16'd1;
            n_ccnt = ccnt;
        end else begin
            n_fsrc = sam ? fsrc : fsrc + sx16(scidx);
            n_fdst = dam ? fdst : fdst + sx16(dcidx);
            n_src  = n_fsrc;
            n_dst  = n_fdst;
            n_bcnt = brld;
            n_ccnt = ccnt - 16'd1;
        end
    end
endmodule

// File: rtl/dma3d_trig.sv
module dma3d_trig #(
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              accept,
    output logic              pending,
    output logic [MISS_W-1:0] missed
);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            missed  <= '0;
        end else begin
            pending <= (pending && !accept) || trig;
            if (trig && pending && !accept && missed != MISS_MAX)
                missed <= missed + 1'b1;
        end
    end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int SLOTS    = 16,
    parameter int ACT_SLOT = 0,
    parameter int MISS_W   = 8,
    localparam int SLOT_AW = $clog2(SLOTS),
    localparam int ADDR_W  = SLOT_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              trig,
    output logic              xfer_valid,
    output logic [31:0]       xfer_src,
    output logic [31:0]       xfer_dst,
    output logic [15:0]       xfer_bytes,
    output logic              xfer_last,
    output logic              irq_final,
    output logic              irq_inter,
    output logic              chain_final,
    output logic              chain_inter,
    output logic [CODE_W-1:0] cc_code,
    output logic [MISS_W-1:0] missed_cnt
);
    seq_state_t st, st_n;

    desc_f_t     act_f;
    desc_f_t     w_f;
    desc_words_t lnk_desc;
    desc_words_t eng_wd;
    logic [DESC_WORDS-1:0] eng_we;

    logic [31:0] w_fsrc, w_fdst;
    logic        armed, fin_q, pending, accept, null_d, act_hit;
    logic        w_sam;

    logic [31:0] n_src, n_dst, n_fsrc, n_fdst;
    logic [15:0] n_bcnt, n_ccnt;
    logic        frame_end, is_final;

    assign w_sam   = w_f.sam;
    assign accept  = (st == S_IDLE) && pending;
    assign null_d  = !armed && (act_f.acnt == 16'd0 || act_f.bcnt == 16'd0 ||
                                act_f.ccnt == 16'd0);
    assign act_hit = cfg_we && (cfg_addr[ADDR_W-1:3] == SLOT_AW'(ACT_SLOT));

    dma3d_pram #(.SLOTS(SLOTS), .ACT_SLOT(ACT_SLOT)) u_pram (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .eng_we   (eng_we),
        .eng_wd   (eng_wd),
        .lnk_sel  (w_f.link[SLOT_AW-1:0]),
        .lnk_desc (lnk_desc),
        .act_f    (act_f)
    );

    dma3d_trig #(.MISS_W(MISS_W)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .accept (accept),
        .pending(pending),
        .missed (missed_cnt)
    );

    dma3d_step u_step (
        .src      (w_f.src),
        .dst      (w_f.dst),
        .fsrc     (w_fsrc),
        .fdst     (w_fdst),
        .bcnt     (w_f.bcnt),
        .ccnt     (w_f.ccnt),
        .brld     (w_f.brld),
        .sbidx    (w_f.sbidx),
        .dbidx    (w_f.dbidx),
        .scidx    (w_f.scidx),
        .dcidx    (w_f.dcidx),
        .sam      (w_f.sam),
        .dam      (w_f.dam),
        .n_src    (n_src),
        .n_dst    (n_dst),
        .n_fsrc   (n_fsrc),
        .n_fdst   (n_fdst),
        .n_bcnt   (n_bcnt),
        .n_ccnt   (n_ccnt),
        .frame_end(frame_end),
        .is_final (is_final)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:   if (accept && !null_d) st_n = S_XFER;
            S_XFER: begin
                if (is_final)                    st_n = w_f.stat ? S_NOTIFY : S_LINK;
                else if (w_f.absync && !frame_end) st_n = S_XFER;
                else                             st_n = w_f.stat ? S_NOTIFY : S_STORE;
            end
            S_STORE:  st_n = S_NOTIFY;
            S_LINK:   st_n = S_NOTIFY;
            S_NOTIFY: st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    // working copy of the active descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_f    <= '0;
            w_fsrc <= '0;
            w_fdst <= '0;
            armed  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            if (accept && !null_d && !armed) begin
                w_f    <= act_f;
                w_fsrc <= act_f.src;
                w_fdst <= act_f.dst;
                armed  <= 1'b1;
            end
            if (st == S_XFER) begin
                w_f.src  <= n_src;
                w_f.dst  <= n_dst;
                w_f.bcnt <= n_bcnt;
                w_f.ccnt <= n_ccnt;
                w_fsrc   <= n_fsrc;
                w_fdst   <= n_fdst;
                fin_q    <= is_final;
                if (is_final) armed <= 1'b0;
            end
            if (act_hit) armed <= 1'b0;
        end
    end

    // engine writes into the active slot
    always_comb begin
        eng_we = '0;
        eng_wd = '0;
        if (st == S_STORE) begin
            eng_we    = 8'b1000_1110;
            eng_wd[1] = w_f.src;
            eng_wd[2] = {w_f.bcnt, w_f.acnt};
            eng_wd[3] = w_f.dst;
            eng_wd[7] = {16'h0, w_f.ccnt};
        end else if (st == S_LINK) begin
            if (w_f.link == NULL_LINK) begin
                eng_we = 8'b1000_0100;
            end else begin
                eng_we = '1;
                eng_wd = lnk_desc;
            end
        end
    end

    // outputs
    always_comb begin
        xfer_valid  = (st == S_XFER);
        xfer_src    = '0;
        xfer_dst    = '0;
        xfer_bytes  = '0;
        xfer_last   = 1'b0;
        irq_final   = 1'b0;
        irq_inter   = 1'b0;
        chain_final = 1'b0;
        chain_inter = 1'b0;
        cc_code     = '0;
        if (st == S_XFER) begin
            xfer_src   = w_f.sam ? fifo_align(w_f.src, w_f.fwid) : w_f.src;
            xfer_dst   = w_f.dam ? fifo_align(w_f.dst, w_f.fwid) : w_f.dst;
            xfer_bytes = w_f.acnt;
            xfer_last  = is_final;
        end
        if (st == S_NOTIFY) begin
            irq_final   = fin_q  && w_f.ie_fin;
            chain_final = fin_q  && w_f.ce_fin;
            irq_inter   = !fin_q && w_f.ie_int;
            chain_inter = !fin_q && w_f.ce_int;
            cc_code     = w_f.code;
        end
    end
endmodule

// File: rtl/dma3d_chk.sv
module dma3d_chk #(
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_valid,
    input logic              xfer_last,
    input logic [15:0]       xfer_bytes,
    input logic [31:0]       xfer_src,
    input logic [MISS_W-1:0] missed_cnt,
    input logic              src_fixed
);
    AST_NO_XFER_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_last |=> !xfer_valid);                               // R6

    AST_MISSED_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> missed_cnt >= $past(missed_cnt));                              // R11

    AST_BURST_BYTES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && $past(xfer_valid) |-> $stable(xfer_bytes));               // R4

    AST_FIXED_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && $past(xfer_valid) && src_fixed |-> $stable(xfer_src));    // R5
endmodule

bind dma3d_seq dma3d_chk #(.MISS_W(MISS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_valid(xfer_valid),
    .xfer_last (xfer_last),
    .xfer_bytes(xfer_bytes),
    .xfer_src  (xfer_src),
    .missed_cnt(missed_cnt),
    .src_fixed (w_sam)
);

// File: tb/sim_dma3d_seq.sv
`timescale 1ns/1ps
module sim_dma3d_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        trig = 1'b0;
    logic        xfer_valid, xfer_last;
    logic [31:0] xfer_src, xfer_dst;
    logic [15:0] xfer_bytes;
    logic        irq_final, irq_inter, chain_final, chain_inter;
    logic [5:0]  cc_code;
    logic [7:0]  missed_cnt;

    always #10 clk = ~clk;

    dma3d_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
        .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_bytes(xfer_bytes), .xfer_last(xfer_last), .irq_final(irq_final),
        .irq_inter(irq_inter), .chain_final(chain_final), .chain_inter(chain_inter),
        .cc_code(cc_code), .missed_cnt(missed_cnt)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] lg_src [64];
    logic [31:0] lg_dst [64];
    logic [15:0] lg_bytes [64];
    logic        lg_last [64];
    int          nx = 0;
    logic [3:0]  nf_kind [16];   // {irq_final, irq_inter, chain_final, chain_inter}
    logic [5:0]  nf_code [16];
    int          nn = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_valid && nx < 64) begin
                lg_src[nx] = xfer_src; lg_dst[nx] = xfer_dst;
                lg_bytes[nx] = xfer_bytes; lg_last[nx] = xfer_last;
                nx++;
            end
            if ((irq_final || irq_inter || chain_final || chain_inter) && nn < 16) begin
                nf_kind[nn] = {irq_final, irq_inter, chain_final, chain_inter};
                nf_code[nn] = cc_code;
                nn++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int slot, input int word, input logic [31:0] d);
        cfg_addr = 7'(slot * 8 + word); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int slot, input int word, output logic [31:0] d);
        cfg_addr = 7'(slot * 8 + word);
        #1;
        d = cfg_rdata;
    endtask

    task automatic fire(input int wait_cyc);
        nx = 0; nn = 0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (wait_cyc) @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 xfer_valid", 32'(xfer_valid), 0);
        chk("R1 notify", 32'({irq_final, irq_inter, chain_final, chain_inter}), 0);
        chk("R1 missed", 32'(missed_cnt), 0);
        rd(0, 0, d); chk("R1 word0", d, 0);
        rd(15, 7, d); chk("R1 word127", d, 0);
    endtask

    task automatic t_regport();
        logic [31:0] d;
        wr(3, 1, 32'hDEADBEEF);
        wr(3, 6, 32'h12345678);
        rd(3, 1, d); chk("R2 slot3 w1", d, 32'hDEADBEEF);
        rd(3, 6, d); chk("R2 slot3 w6", d, 32'h12345678);
        rd(3, 2, d); chk("R2 slot3 w2 untouched", d, 0);
    endtask

    task automatic t_async();
        logic [31:0] d;
        logic [31:0] es [5] = '{32'h1000, 32'h1010, 32'h1100, 32'h1110, 32'h1120};
        logic [31:0] ed [5] = '{32'h2000, 32'h2020, 32'h1FC0, 32'h1FE0, 32'h2000};
        wr(0, 0, 32'h0030_5000); wr(0, 1, 32'h1000); wr(0, 2, 32'h0002_0004);
        wr(0, 3, 32'h2000);      wr(0, 4, 32'h0020_0010); wr(0, 5, 32'h0003_FFFF);
        wr(0, 6, 32'hFFC0_0100); wr(0, 7, 32'h2);
        // latency of the first array
        nx = 0; nn = 0;
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk("R3 no array one edge after trigger", 32'(xfer_valid), 0);
        @(negedge clk);
        chk("R3 array two edges after trigger", 32'(xfer_valid), 1);
        repeat (6) @(negedge clk);
        #2;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) fire(8);
            chk("R3 one array per trigger", 32'(nx), 1);
            chk("R3 src", lg_src[0], es[k]);
            chk("R3 dst", lg_dst[0], ed[k]);
            chk("R3 bytes", 32'(lg_bytes[0]), 4);
            chk("R6 last flag", 32'(lg_last[0]), (k == 4) ? 1 : 0);
            chk("R10 one pulse", 32'(nn), 1);
            chk("R10 pulse kind", 32'(nf_kind[0]), (k == 4) ? 32'b1000 : 32'b0100);
            chk("R10 code", 32'(nf_code[0]), 5);
            if (k == 0) begin
                rd(0, 1, d); chk("R12 stored src", d, 32'h1010);
                rd(0, 3, d); chk("R12 stored dst", d, 32'h2020);
                rd(0, 2, d); chk("R12 stored B", d, 32'h0001_0004);
                rd(0, 7, d); chk("R12 stored C", d, 32'h2);
            end
            if (k == 1) begin
                rd(0, 1, d); chk("R12 stored src frame1", d, 32'h1100);
                rd(0, 2, d); chk("R12 B reloaded", d, 32'h0003_0004);
                rd(0, 7, d); chk("R12 C decremented", d, 32'h1);
            end
        end
        rd(0, 2, d); chk("R8 counts cleared w2", d, 0);
        rd(0, 7, d); chk("R8 counts cleared w7", d, 0);
        fire(8);
        chk("R8 trigger ignored arrays", 32'(nx), 0);
        chk("R8 trigger ignored pulses", 32'(nn), 0);
    endtask

    task automatic t_absync_link_static();
        logic [31:0] d;
        logic [31:0] s2 [8] = '{32'h0010_1008, 32'h8000, 32'h0001_0002, 32'h9000,
                                32'h0, 32'h0000_0003, 32'h0, 32'h1};
        for (int w = 0; w < 8; w++) wr(2, w, s2[w]);
        wr(0, 0, 32'h00C0_9206); wr(0, 1, 32'h4000); wr(0, 2, 32'h0003_0008);
        wr(0, 3, 32'h5007);      wr(0, 4, 32'h0004_0008); wr(0, 5, 32'h0003_0002);
        wr(0, 6, 32'h0000_0040); wr(0, 7, 32'h2);
        fire(10);
        chk("R4 arrays per trigger", 32'(nx), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 src step", lg_src[i], 32'h4000 + 32'(i * 8));
            chk("R5 fixed dst aligned", lg_dst[i], 32'h5004);
            chk("R6 last clear frame0", 32'(lg_last[i]), 0);
        end
        chk("R10 chain_inter pulse", 32'(nf_kind[0]), 32'b0001);
        chk("R10 code 9", 32'(nf_code[0]), 9);
        fire(10);
        chk("R4 arrays second frame", 32'(nx), 3);
        chk("R3 C index on frame start", lg_src[0], 32'h4040);
        chk("R4 src frame1 end", lg_src[2], 32'h4050);
        chk("R6 last on final", 32'(lg_last[2]), 1);
        chk("R6 last clear before", 32'(lg_last[1]), 0);
        chk("R10 chain_final pulse", 32'(nf_kind[0]), 32'b0010);
        for (int w = 0; w < 8; w++) begin
            rd(0, w, d); chk("R7 linked word copied", d, s2[w]);
        end
        for (int r = 0; r < 2; r++) begin
            fire(8);
            chk("R9 static array count", 32'(nx), 1);
            chk("R9 static src", lg_src[0], 32'h8000);
            chk("R9 static dst", lg_dst[0], 32'h9000);
            chk("R9 static last", 32'(lg_last[0]), 1);
            chk("R10 irq_final code1", {26'h0, nf_code[0]}, 1);
            chk("R10 irq_final kind", 32'(nf_kind[0]), 32'b1000);
            rd(0, 1, d); chk("R9 src unchanged", d, 32'h8000);
            rd(0, 7, d); chk("R9 C unchanged", d, 32'h1);
            rd(0, 0, d); chk("R9 opt unchanged", d, s2[0]);
        end
    endtask

    task automatic t_pending();
        wr(0, 0, 32'h0010_000C); wr(0, 1, 32'hA000); wr(0, 2, 32'h0004_0001);
        wr(0, 3, 32'hB000);      wr(0, 4, 32'h0001_0001); wr(0, 5, 32'h0000_FFFF);
        wr(0, 6, 32'h0);         wr(0, 7, 32'h1);
        nx = 0; nn = 0;
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        @(negedge clk);
        trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        repeat (25) @(negedge clk);
        #2;
        chk("R11 both triggers served", 32'(nx), 8);
        chk("R11 second burst start", lg_src[4], 32'hA000);
        chk("R11 second burst end", lg_src[7], 32'hA003);
        chk("R11 two completions", 32'(nn), 2);
        chk("R11 missed count", 32'(missed_cnt), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_regport();
        t_async();
        t_absync_link_static();
        t_pending();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule